// File: doc/BRIEF.md
# Counterflow Operand Pipeline

This block executes a stream of simple register-to-register operations without any bypass multiplexers. It holds two token pipes that run in opposite directions over the same row of stages. Operation tokens enter at stage 0 and step toward the register file, which sits behind the last stage. Result tokens step the other way and leave the pipe past stage 0. Wherever an operation token and a result token occupy the same stage, the operation copies any result whose register tag matches a source it still lacks. The result is discarded if the operation will itself overwrite that register.

An operation whose sources are all present executes at the first stage from the execute stage onward that can also launch its result into the result pipe. An operation that reaches the last stage still missing a source reads it from the register file and executes there. Every operation carries its result to the last stage, where it leaves through the retire port and is written into the register file. Operations retire one per cycle at most, strictly in the order they were accepted.

Top module: `cfp_pipe`

## Requirements
- R1: After reset, `in_ready_o` is high, `ret_valid_o` is low, and all eight 16-bit registers read as zero.
- R2: An operation accepted into an empty pipe appears on the retire port exactly STAGES-1 cycles after the clock edge that accepted it.
- R3: An operation that depends on an older operation still in flight retires with the value computed from that older operation's result.
- R4: When several older operations write the same register, a dependent operation uses the value from the youngest of them that is older than itself.
- R5: A source register with no matching older write in flight is read from the register file, which holds every value retired so far.
- R6: Opcode encodings are 0 = add (a+b), 1 = subtract (a-b), 2 = xor (a^b), 3 = load immediate (result = `in_imm_i`). A load immediate ignores both source fields.
- R7: Operations retire in acceptance order, with the destination tag on `ret_tag_o` and the value on `ret_data_o`, and each retired value is written to the register file at that clock edge.
- R8: An operation is accepted only on an edge where `in_valid_i` and `in_ready_o` are both high. Each accepted operation retires exactly once.
- R9: All arithmetic is modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Stage 0 can take an operation this edge |
| in_op_i | input | 2 | Opcode (see R6) |
| in_dst_i | input | 3 | Destination register |
| in_src_a_i | input | 3 | First source register |
| in_src_b_i | input | 3 | Second source register |
| in_imm_i | input | 16 | Immediate for load |
| ret_valid_o | output | 1 | An operation retires this cycle |
| ret_tag_o | output | 3 | Destination of the retiring operation |
| ret_data_o | output | 16 | Value written back |

## Verification
A wrong snoop or a missed discard of a superseded result shows up as a wrong `ret_data_o` when the dependent operation retires, at most STAGES-1 cycles after the bad capture. A lost or duplicated token shifts every following retire, so the next comparison against the in-order expected stream catches it. Flow-control faults appear either as an R2 latency mismatch or as a count mismatch after the final drain.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  parameter int TAG_W  = 3;
  parameter int DATA_W = 16;
  // sequence width must cover about 2*STAGES+1 tokens in flight
  parameter int SEQ_W  = 5;

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [DATA_W-1:0] word_t;
  typedef logic [SEQ_W-1:0]  seq_t;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_XOR = 2'd2,
    OP_LDI = 2'd3
  } op_e;

  typedef struct packed {
    logic  v;
    seq_t  seq;
    op_e   op;
    tag_t  dst;
    tag_t  sa;
    tag_t  sb;
    logic  ha;
    logic  hb;
    word_t va;
    word_t vb;
    logic  done;
    word_t res;
  } ins_t;

  typedef struct packed {
    logic  v;
    seq_t  seq;
    tag_t  tag;
    word_t val;
  } res_t;

  function automatic word_t alu(op_e op, word_t a, word_t b);
    word_t r;
    case (op)
      OP_ADD:  r = a + b;
      OP_SUB:  r = a - b;
      OP_XOR:  r = a ^ b;
      default: r = a;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cfp_meet.sv
module cfp_meet
  import cfp_pkg::*;
(
  input  ins_t ins_i,
  input  res_t res_i,
  output ins_t ins_o,
  output res_t res_o
);
  logic hit;
  assign hit = ins_i.v && res_i.v;

  always_comb begin
    ins_o = ins_i;
    res_o = res_i;
    if (hit) begin
      if (!ins_i.ha && ins_i.sa == res_i.tag) begin
        ins_o.ha = 1'b1;
        ins_o.va = res_i.val;
      end
      if (!ins_i.hb && ins_i.sb == res_i.tag) begin
        ins_o.hb = 1'b1;
        ins_o.vb = res_i.val;
      end
      // a younger writer of the same register supersedes this result
      if (ins_i.dst == res_i.tag && ins_i.seq != res_i.seq) res_o.v = 1'b0;
    end
  end
endmodule

// File: rtl/cfp_regfile.sv
module cfp_regfile
  import cfp_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  tag_t  wa_i,
  input  word_t wd_i,
  input  tag_t  ra_a_i,
  input  tag_t  ra_b_i,
  output word_t rd_a_o,
  output word_t rd_b_o
);
  word_t mem [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[wa_i] <= wd_i;
    end
  end

  assign rd_a_o = mem[ra_a_i];
  assign rd_b_o = mem[ra_b_i];
endmodule

// File: rtl/cfp_pipe.sv
module cfp_pipe
  import cfp_pkg::*;
#(
  parameter int STAGES   = 4,
  parameter int EX_STAGE = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_valid_i,
  output logic                      in_ready_o,
  input  logic [1:0]                in_op_i,
  input  logic [cfp_pkg::TAG_W-1:0] in_dst_i,
  input  logic [cfp_pkg::TAG_W-1:0] in_src_a_i,
  input  logic [cfp_pkg::TAG_W-1:0] in_src_b_i,
  input  logic [cfp_pkg::DATA_W-1:0] in_imm_i,
  output logic                      ret_valid_o,
  output logic [cfp_pkg::TAG_W-1:0] ret_tag_o,
  output logic [cfp_pkg::DATA_W-1:0] ret_data_o
);
  localparam int LAST = STAGES - 1;
  localparam int NREG = 1 << TAG_W;

  ins_t ins_q [STAGES];
  ins_t ins_m [STAGES];
  ins_t ins_x [STAGES];
  ins_t ins_d [STAGES];
  res_t res_q [STAGES];
  res_t res_m [STAGES];
  res_t res_d [STAGES];

  logic [STAGES-1:0] ileave;
  logic [LAST-1:0]   imv;
  logic [LAST-1:0]   rmv;
  seq_t  seq_q;
  word_t rd_a, rd_b;
  ins_t  ins_new;
  logic  accept;

  function automatic ins_t run_op(ins_t t, logic go);
    ins_t r;
    r = t;
    if (go) begin
      r.done = 1'b1;
      r.res  = alu(t.op, t.va, t.vb);
    end
    return r;
  endfunction

  function automatic res_t mk_res(ins_t t);
    res_t r;
    r.v   = 1'b1;
    r.seq = t.seq;
    r.tag = t.dst;
    r.val = t.res;
    return r;
  endfunction

  assign in_ready_o = !ins_q[0].v || ileave[0];
  assign accept     = in_valid_i && in_ready_o;

  always_comb begin
    ins_new      = '0;
    ins_new.v    = 1'b1;
    ins_new.seq  = seq_q;
    ins_new.op   = op_e'(in_op_i);
    ins_new.dst  = in_dst_i;
    ins_new.sa   = in_src_a_i;
    ins_new.sb   = in_src_b_i;
    ins_new.ha   = (op_e'(in_op_i) == OP_LDI);
    ins_new.hb   = (op_e'(in_op_i) == OP_LDI);
    ins_new.va   = in_imm_i;
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_st
    cfp_meet u_meet (
      .ins_i (ins_q[k]),
      .res_i (res_q[k]),
      .ins_o (ins_m[k]),
      .res_o (res_m[k])
    );

    if (k < LAST) begin : g_mid
      logic ex;
      // results never stall; a result crossing boundary k blocks the instruction there
      assign rmv[k] = res_m[k+1].v;
      assign ex = (k >= EX_STAGE) && ins_m[k].v && ins_m[k].ha && ins_m[k].hb &&
                  !ins_m[k].done && !res_m[k+1].v;
      assign ins_x[k]  = run_op(ins_m[k], ex);
      assign imv[k]    = ins_m[k].v && !rmv[k] && (!ins_q[k+1].v || ileave[k+1]);
      assign ileave[k] = imv[k];
      assign res_d[k]  = rmv[k] ? res_m[k+1] : (ex ? mk_res(ins_x[k]) : res_t'('0));
    end else begin : g_last
      ins_t filled;
      always_comb begin
        filled = ins_m[k];
        if (!ins_m[k].ha) filled.va = rd_a;
        if (!ins_m[k].hb) filled.vb = rd_b;
      end
      assign ins_x[k]  = run_op(filled, !filled.done);
      assign ileave[k] = ins_q[k].v;
      assign res_d[k]  = (ins_m[k].v && !ins_m[k].done) ? mk_res(ins_x[k]) : res_t'('0);
    end

    if (k == 0) begin : g_head
      assign ins_d[k] = accept ? ins_new : (ileave[k] ? ins_t'('0) : ins_x[k]);
    end else begin : g_body
      assign ins_d[k] = imv[k-1] ? ins_x[k-1] : (ileave[k] ? ins_t'('0) : ins_x[k]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) begin
        ins_q[k] <= '0;
        res_q[k] <= '0;
      end
      seq_q <= '0;
    end else begin
      for (int k = 0; k < STAGES; k++) begin
        ins_q[k] <= ins_d[k];
        res_q[k] <= res_d[k];
      end
      if (accept) seq_q <= seq_q + 1'b1;
    end
  end

  cfp_regfile #(.NREG(NREG)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ins_q[LAST].v),
    .wa_i   (ins_q[LAST].dst),
    .wd_i   (ins_x[LAST].res),
    .ra_a_i (ins_q[LAST].sa),
    .ra_b_i (ins_q[LAST].sb),
    .rd_a_o (rd_a),
    .rd_b_o (rd_b)
  );

  assign ret_valid_o = ins_q[LAST].v;
  assign ret_tag_o   = ins_q[LAST].dst;
  assign ret_data_o  = ins_x[LAST].res;

  // checker state: retire sequence expected in acceptance order
  seq_t ret_seq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ret_seq_q <= '0;
    else if (ret_valid_o) ret_seq_q <= ret_seq_q + 1'b1;
  end

  p_fwd_a_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_q[LAST].v && ins_q[LAST].ha && ins_q[LAST].op != OP_LDI) |-> (ins_q[LAST].va == rd_a));

  p_fwd_b_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_q[LAST].v && ins_q[LAST].hb && ins_q[LAST].op != OP_LDI) |-> (ins_q[LAST].vb == rd_b));

  p_early_exec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_q[LAST].v && ins_q[LAST].done && ins_q[LAST].op != OP_LDI) |->
      (ins_q[LAST].res == alu(ins_q[LAST].op, rd_a, rd_b)));

  p_wb_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o |-> (ins_q[LAST].seq == ret_seq_q));

  p_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (ins_q[0].v && ins_q[0].seq == $past(seq_q)));

  p_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !in_ready_o) |=> (seq_q == $past(seq_q)));
endmodule

// File: tb/cfp_pipe_test.sv
`timescale 1ns/1ps
module cfp_pipe_test;
  localparam int STAGES = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = '0;
  logic [2:0]  in_dst = '0, in_sa = '0, in_sb = '0;
  logic [15:0] in_imm = '0;
  logic        ret_valid;
  logic [2:0]  ret_tag;
  logic [15:0] ret_data;

  always #4 clk = ~clk;

  cfp_pipe #(.STAGES(STAGES), .EX_STAGE(2)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_op_i(in_op), .in_dst_i(in_dst), .in_src_a_i(in_sa), .in_src_b_i(in_sb),
    .in_imm_i(in_imm),
    .ret_valid_o(ret_valid), .ret_tag_o(ret_tag), .ret_data_o(ret_data)
  );

  int checks = 0, errors = 0, cyc = 0;
  int acc_cyc = 0, last_ret_cyc = 0;
  int sent = 0, retired = 0;
  bit finished = 0;
  logic [15:0] mrf [8];
  logic [2:0]  q_tag [1024];
  logic [15:0] q_val [1024];
  int          q_req [1024];
  int q_head = 0, q_tail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] model_op(int op, logic [15:0] a, logic [15:0] b, logic [15:0] imm);
    case (op)
      0: return a + b;    // R6 add, R9 wrap
      1: return a - b;    // R6 subtract
      2: return a ^ b;    // R6 xor
      default: return imm; // R6 load immediate ignores sources
    endcase
  endfunction

  // R7: expected queue is in program order; each retire must match its head
  always @(negedge clk) begin
    if (rst_n && ret_valid) begin
      checks++;
      retired++;
      last_ret_cyc = cyc;
      if (q_head == q_tail) begin
        errors++;
        $display("FAIL R8 unexpected retire actual %0d/%h expected none", ret_tag, ret_data);
      end else begin
        if (ret_tag !== q_tag[q_head] || ret_data !== q_val[q_head]) begin
          errors++;
          $display("FAIL R%0d retire actual %0d/%h expected %0d/%h",
                   q_req[q_head], ret_tag, ret_data, q_tag[q_head], q_val[q_head]);
        end
        q_head++;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic send(int op, int dst, int sa, int sb, logic [15:0] imm, int req);
    logic [15:0] v;
    @(negedge clk);
    in_op = 2'(op); in_dst = 3'(dst); in_sa = 3'(sa); in_sb = 3'(sb); in_imm = imm;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    acc_cyc = cyc;
    in_valid = 1'b0;
    v = model_op(op, mrf[sa], mrf[sb], imm);
    mrf[dst] = v;
    q_tag[q_tail] = 3'(dst);
    q_val[q_tail] = v;
    q_req[q_tail] = req;
    q_tail++;
    sent++;
  endtask

  task automatic drain();
    int guard = 0;
    while (q_head != q_tail && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic check_lat(string tag);
    checks++;
    if (last_ret_cyc - acc_cyc != STAGES - 1) begin
      errors++;
      $display("FAIL %s latency actual %0d expected %0d", tag, last_ret_cyc - acc_cyc, STAGES - 1);
    end
  endtask

  function automatic int pick_reg();
    if ($urandom_range(0, 3) == 0) return int'($urandom_range(0, 7));
    return int'($urandom_range(0, 3));
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) mrf[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (in_ready !== 1'b1 || ret_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset ready/retire actual %b/%b expected 1/0", in_ready, ret_valid);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send(0, 5, 6, 7, 16'h0, 1);        // R1: registers read zero
    drain();
    send(3, 2, 0, 0, 16'h1234, 2);     // R2: isolated load latency
    drain();
    check_lat("R2");
    send(0, 3, 2, 2, 16'h0, 5);        // R2/R5: executes at the end from the file
    drain();
    check_lat("R2");

    send(3, 1, 0, 0, 16'd5, 4);        // R4: two writers back to back
    send(3, 1, 0, 0, 16'd9, 4);
    send(0, 2, 1, 1, 16'h0, 4);        // expects 18
    send(3, 1, 0, 0, 16'd7, 4);
    send(0, 1, 1, 1, 16'h0, 4);        // 14, supersedes 7
    send(0, 3, 1, 1, 16'h0, 4);        // expects 28
    drain();

    send(0, 6, 2, 3, 16'h0, 5);        // R5: both sources from the file
    send(3, 4, 1, 2, 16'hBEEF, 6);     // R6: sources ignored
    send(2, 5, 4, 1, 16'h0, 6);
    send(1, 6, 1, 4, 16'h0, 6);
    drain();

    send(3, 0, 0, 0, 16'hFFFF, 9);     // R9 wrap
    send(3, 7, 0, 0, 16'd2, 9);
    send(0, 0, 0, 7, 16'h0, 9);        // 0xFFFF+2 = 1
    send(1, 3, 0, 7, 16'h0, 9);        // 1-2 = 0xFFFF
    drain();

    // R3: random dependent stream
    for (int i = 0; i < 400; i++) begin
      send(int'($urandom_range(0, 3)), pick_reg(), pick_reg(), pick_reg(),
           16'($urandom()), 3);
      if ($urandom_range(0, 5) == 0) repeat (int'($urandom_range(1, 3))) @(negedge clk);
    end
    drain();

    // R8: every accepted operation retired exactly once
    checks++;
    if (retired != sent || q_head != q_tail) begin
      errors++;
      $display("FAIL R8 retired count actual %0d expected %0d", retired, sent);
    end
    finish_run();
  end
endmodule